// File: doc/BRIEF.md
# Line Loss-of-Signal Detector

This block watches received bipolar line data, presented as a positive-mark strobe and a negative-mark strobe with one bit per recovered clock period. Each bit period is announced by a valid strobe. The block raises a loss-of-signal flag after a long unbroken run of spaces.

Once the flag is up, it is cleared only by a density test. Enough marks must appear inside a sliding window of recent bits, and that window must hold no overly long zero run. The received strobes are copied to the outputs one bit period later, whatever the state of the flag. Downstream logic can therefore keep decoding data while the alarm is raised.

Top module: `line_los_monitor`

## Requirements
- R1: `los_o` goes high on the clock edge that accepts the 175th consecutive space. After a mark, 174 further spaces leave it low.
- R2: When `los_o` is high, it clears only on an accepted bit after which the last 128 accepted bits hold at least 16 marks. With 15 or fewer marks it stays high, for example with one mark every 9 bits.
- R3: `los_o` does not clear while any run of 100 or more consecutive spaces lies inside the last 128 accepted bits. Bits older than 128 positions no longer block it.
- R4: `rpos_o` and `rneg_o` take the values of `rpos_i` and `rneg_i` on every accepted bit, including while `los_o` is high.
- R5: A bit is a mark when `rpos_i` or `rneg_i` is high, including when both are high. It is a space only when both are low.
- R6: On a clock edge with `bit_valid_i` low, every output and all internal history keep their values.
- R7: Reset drives `los_o` high and `rpos_o`/`rneg_o` low. It also empties the bit history and the run counters, so the first 16 marks after reset clear `los_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Recovered bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_valid_i | input | 1 | High on cycles that carry a received bit |
| rpos_i | input | 1 | Positive mark strobe |
| rneg_i | input | 1 | Negative mark strobe |
| rpos_o | output | 1 | Registered positive mark strobe |
| rneg_o | output | 1 | Registered negative mark strobe |
| los_o | output | 1 | Loss-of-signal flag |

## Verification
Two conditions can fall on the same bit: the mark count reaching its threshold, and the expiry of the hold that blocks recovery after a long zero run. One scenario follows a run of 175 spaces with dense marks, so the count is already satisfied while the hold still runs. The flag must then fall on exactly the 29th mark, when the last 100-space stretch leaves the window. A second scenario sends one mark every 8 bits, so the 16th mark arrives after the hold has run out, and the flag must fall on exactly that bit.

// File: rtl/los_pkg.sv
package los_pkg;
  localparam int unsigned WIN_BITS_DEF  = 128;
  localparam int unsigned MIN_MARKS_DEF = 16;
  localparam int unsigned SET_RUN_DEF   = 175;
  localparam int unsigned GAP_RUN_DEF   = 100;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/los_zero_run.sv
module los_zero_run #(
  parameter int unsigned RUN_MAX = 175,
  localparam int unsigned RW     = $clog2(RUN_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          mark_i,
  output logic [RW-1:0] run_nxt_o,
  output logic [RW-1:0] run_q_o
);
  logic [RW-1:0] run_q;

  always_comb begin
    run_nxt_o = run_q;
    if (adv_i) begin
      if (mark_i)                      run_nxt_o = '0;
      else if (run_q != RW'(RUN_MAX))  run_nxt_o = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else         run_q <= run_nxt_o;
  end

  assign run_q_o = run_q;

  p_run_sat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RW'(RUN_MAX));
  p_run_mark_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && mark_i) |=> (run_q == '0));
  p_run_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(run_q));
endmodule

// File: rtl/los_window_cnt.sv
module los_window_cnt #(
  parameter int unsigned WIN    = 128,
  localparam int unsigned CW    = $clog2(WIN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          mark_i,
  output logic [CW-1:0] cnt_nxt_o,
  output logic [CW-1:0] cnt_q_o
);
  logic [WIN-1:0] hist_q;
  logic [CW-1:0]  cnt_q;
  logic           old_bit;

  assign old_bit = hist_q[WIN-1];

  always_comb begin
    cnt_nxt_o = cnt_q;
    if (adv_i) cnt_nxt_o = cnt_q + CW'(mark_i) - CW'(old_bit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      cnt_q  <= '0;
    end else if (adv_i) begin
      hist_q <= {hist_q[WIN-2:0], mark_i};
      cnt_q  <= cnt_nxt_o;
    end
  end

  assign cnt_q_o = cnt_q;

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(WIN));
  p_cnt_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1) ||
               (cnt_q == $past(cnt_q) - 1'b1)));
  p_cnt_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> ($stable(cnt_q) && $stable(hist_q)));
endmodule

// File: rtl/los_gap_guard.sv
module los_gap_guard #(
  parameter int unsigned WIN    = 128,
  parameter int unsigned GAP    = 100,
  parameter int unsigned RW     = 8,
  localparam int unsigned HOLD  = WIN - GAP + 1,
  localparam int unsigned HW    = $clog2(HOLD + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic [RW-1:0] run_nxt_i,
  output logic          clean_nxt_o,
  output logic [HW-1:0] hold_q_o
);
  logic [HW-1:0] hold_q, hold_nxt;

  // hold counts bits until the last GAP-long zero stretch leaves the window
  always_comb begin
    hold_nxt = hold_q;
    if (adv_i) begin
      if (run_nxt_i >= RW'(GAP))  hold_nxt = HW'(HOLD);
      else if (hold_q != '0)      hold_nxt = hold_q - 1'b1;
    end
  end

  assign clean_nxt_o = (hold_nxt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else         hold_q <= hold_nxt;
  end

  assign hold_q_o = hold_q;

  p_hold_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q <= HW'(HOLD));
  p_hold_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && run_nxt_i >= RW'(GAP)) |=> (hold_q == HW'(HOLD)));
endmodule

// File: rtl/line_los_monitor.sv
module line_los_monitor #(
  parameter int unsigned WIN_BITS  = los_pkg::WIN_BITS_DEF,
  parameter int unsigned MIN_MARKS = los_pkg::MIN_MARKS_DEF,
  parameter int unsigned SET_RUN   = los_pkg::SET_RUN_DEF,
  parameter int unsigned GAP_RUN   = los_pkg::GAP_RUN_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_valid_i,
  input  logic rpos_i,
  input  logic rneg_i,
  output logic rpos_o,
  output logic rneg_o,
  output logic los_o
);
  localparam int unsigned RUN_MAX = los_pkg::max_u(SET_RUN, GAP_RUN);
  localparam int unsigned RW      = $clog2(RUN_MAX + 1);
  localparam int unsigned CW      = $clog2(WIN_BITS + 1);
  localparam int unsigned HW      = $clog2(WIN_BITS - GAP_RUN + 2);

  logic          mark;
  logic [RW-1:0] run_nxt, run_q;
  logic [CW-1:0] cnt_nxt, cnt_q;
  logic [HW-1:0] hold_q;
  logic          clean_nxt;
  logic          los_q, los_d;
  logic          rpos_q, rneg_q;

  assign mark = rpos_i | rneg_i;

  los_zero_run #(.RUN_MAX(RUN_MAX)) u_run (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(bit_valid_i), .mark_i(mark),
    .run_nxt_o(run_nxt), .run_q_o(run_q)
  );

  los_window_cnt #(.WIN(WIN_BITS)) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(bit_valid_i), .mark_i(mark),
    .cnt_nxt_o(cnt_nxt), .cnt_q_o(cnt_q)
  );

  los_gap_guard #(.WIN(WIN_BITS), .GAP(GAP_RUN), .RW(RW)) u_gap (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(bit_valid_i), .run_nxt_i(run_nxt),
    .clean_nxt_o(clean_nxt), .hold_q_o(hold_q)
  );

  always_comb begin
    los_d = los_q;
    if (bit_valid_i) begin
      if (run_nxt >= RW'(SET_RUN))                      los_d = 1'b1;
      else if (los_q && cnt_nxt >= CW'(MIN_MARKS) && clean_nxt) los_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      los_q  <= 1'b1;
      rpos_q <= 1'b0;
      rneg_q <= 1'b0;
    end else begin
      los_q <= los_d;
      if (bit_valid_i) begin
        rpos_q <= rpos_i;
        rneg_q <= rneg_i;
      end
    end
  end

  assign los_o  = los_q;
  assign rpos_o = rpos_q;
  assign rneg_o = rneg_q;

  p_los_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(los_o) |-> (run_q >= RW'(SET_RUN)));
  p_los_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(los_o) |-> (cnt_q >= CW'(MIN_MARKS)));
  p_los_fall_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(los_o) |-> (hold_q == '0 && run_q < RW'(GAP_RUN)));
  p_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_i |=> (rpos_o == $past(rpos_i) && rneg_o == $past(rneg_i)));
  p_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_i |=> ($stable(los_o) && $stable(rpos_o) && $stable(rneg_o)));
endmodule

// File: tb/line_los_monitor_tb_top.sv
module line_los_monitor_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0;
  logic rpos = 1'b0;
  logic rneg = 1'b0;
  logic rpos_o, rneg_o, los_o;
  int   checks = 0;
  int   errors = 0;

  always #5 clk = ~clk;

  line_los_monitor dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bit_valid_i(bit_valid),
    .rpos_i(rpos), .rneg_i(rneg),
    .rpos_o(rpos_o), .rneg_o(rneg_o), .los_o(los_o)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic p, input logic n);
    @(negedge clk);
    rpos = p; rneg = n; bit_valid = 1'b1;
    @(posedge clk);
    #1;
  endtask

  task automatic send_zeros(input int count);
    for (int i = 0; i < count; i++) send_bit(1'b0, 1'b0);
  endtask

  task automatic idle_line();
    @(negedge clk);
    bit_valid = 1'b0; rpos = 1'b0; rneg = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R7", "los after reset", los_o, 1'b1);
    chk("R7", "rpos_o after reset", rpos_o, 1'b0);
    chk("R7", "rneg_o after reset", rneg_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R2 R5 R7: 16 mixed-polarity marks clear the flag after reset
  task automatic t_first_recovery();
    for (int i = 1; i <= 16; i++) begin
      case (i % 3)
        0: send_bit(1'b1, 1'b0);
        1: send_bit(1'b0, 1'b1);
        default: send_bit(1'b1, 1'b1);
      endcase
      if (i == 15) chk("R2", "los after 15 marks", los_o, 1'b1);
    end
    chk("R5", "los after 16 marks of any polarity", los_o, 1'b0);
  endtask

  // R6: invalid cycles are ignored
  task automatic t_valid_gate();
    send_bit(1'b1, 1'b0);
    idle_line();
    rpos = 1'b0;
    repeat (300) @(posedge clk);
    #1;
    chk("R6", "los held while invalid", los_o, 1'b0);
    chk("R6", "rpos_o held while invalid", rpos_o, 1'b1);
    chk("R6", "rneg_o held while invalid", rneg_o, 1'b0);
  endtask

  // R1: exact threshold
  task automatic t_assert_run();
    send_zeros(174);
    chk("R1", "los after 174 spaces", los_o, 1'b0);
    send_bit(1'b0, 1'b0);
    chk("R1", "los after 175 spaces", los_o, 1'b1);
  endtask

  // R3 R4: dense marks after long run; hold and count meet on one bit
  task automatic t_gap_hold();
    for (int i = 1; i <= 29; i++) begin
      logic p, n;
      p = (i % 2 == 1);
      n = (i % 2 == 0) || (i % 5 == 0);
      send_bit(p, n);
      if (i == 3 || i == 20) begin
        chk("R4", "rpos pass with los high", rpos_o, p);
        chk("R4", "rneg pass with los high", rneg_o, n);
      end
      if (i == 16) chk("R3", "los with 16 marks and long run in window", los_o, 1'b1);
      if (i == 28) chk("R3", "los with 100-space stretch still in window", los_o, 1'b1);
    end
    chk("R3", "los once stretch left window", los_o, 1'b0);
  endtask

  // R2: one mark every 8 bits reaches 16 in 128
  task automatic t_sparse_ok();
    send_zeros(175);
    chk("R1", "los re-asserted", los_o, 1'b1);
    for (int i = 1; i <= 128; i++) begin
      send_bit((i % 8) == 0, 1'b0);
      if (i == 127) chk("R2", "los before 16th sparse mark", los_o, 1'b1);
    end
    chk("R2", "los at 12.5 percent density", los_o, 1'b0);
  endtask

  // R2: one mark every 9 bits never reaches 16 in 128
  task automatic t_sparse_low();
    logic seen_low;
    send_zeros(175);
    seen_low = 1'b0;
    for (int i = 1; i <= 300; i++) begin
      send_bit(1'b0, (i % 9) == 0);
      if (!los_o) seen_low = 1'b1;
    end
    chk("R2", "los stays high below density", seen_low, 1'b0);
    chk("R2", "los final below density", los_o, 1'b1);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_first_recovery();
    t_valid_gate();
    t_assert_run();
    t_gap_hold();
    t_sparse_ok();
    t_sparse_low();
    idle_line();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule